// File: doc/BRIEF.md
# Bit-Sliced Arithmetic/Logic Unit with Set-Less-Than

This block is a purely combinational arithmetic/logic unit assembled from `WIDTH` identical one-bit slices. Each slice holds a full adder, an AND gate, an OR gate and a four-way result selector. A small control decoder sits above the slices. It turns a 3-bit operation code into one invert line and four one-hot select lines, and those lines drive every slice. The unit performs addition, subtraction, bitwise AND, bitwise OR and a signed set-on-less-than.

The carries ripple from the least significant slice upward. The carry into slice 0 is the invert bit itself, so a subtraction adds the inverted B operand plus one. The sum bit of the top slice is routed back to the "less" input of slice 0, and the less inputs of all other slices are tied low. The comparison therefore uses only the sign of the wrapped difference, and no overflow correction is applied. Overflow is not detected.

Top module: `ripple_slt_alu`

## Requirements
- R1: `op_code[2]` inverts the B operand and is also the carry into slice 0. `op_code[1:0]` selects the result source: 00 gives AND, 01 gives OR, 10 gives the adder sum and 11 gives the less path.
- R2: With code 010, `alu_out` equals `(opnd_a + opnd_b) mod 2^WIDTH`.
- R3: With code 110, `alu_out` equals `(opnd_a - opnd_b) mod 2^WIDTH`.
- R4: With code 000, `alu_out` equals `opnd_a & opnd_b`.
- R5: With code 001, `alu_out` equals `opnd_a | opnd_b`.
- R6: With code 111, `alu_out` bit 0 equals bit `WIDTH-1` of `(opnd_a - opnd_b) mod 2^WIDTH` and all higher bits are 0. When the subtraction overflows, the answer is deliberately wrong (for example 0x80 vs 0x01 gives 0).
- R7: For every code, `carry_top` is bit `WIDTH` of `opnd_a + (opnd_b XOR {WIDTH{op_code[2]}}) + op_code[2]`. For subtraction this is 1 exactly when `opnd_a >= opnd_b` as unsigned values.
- R8: With the invert bit set on the logic codes, code 100 gives `opnd_a & ~opnd_b` and code 101 gives `opnd_a | ~opnd_b`.
- R9: With code 011, `alu_out` bit 0 equals bit `WIDTH-1` of `(opnd_a + opnd_b) mod 2^WIDTH` and all higher bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand, optionally inverted |
| op_code | input | 3 | Bit 2 is the B invert; bits 1:0 select the result source |
| alu_out | output | WIDTH | Selected result |
| carry_top | output | 1 | Carry out of the most significant slice |

## Verification
The bench uses the default `WIDTH` of 8. At that width the signed overflow boundaries at 0x7F and 0x80 and the unsigned wrap at 0xFF can be hit directly. At that width an evenly strided sweep of both operands also covers every sign combination for all eight operation codes. Directed vectors around these boundaries expose the deliberate set-less-than error on overflow, the carry-out polarity for subtraction and the routing of the top sum bit back to bit 0.

// File: rtl/alu_slice_pkg.sv
// Package: shared encodings for the bit-sliced ALU.
// Assumes op_code[2] is the B invert and op_code[1:0] is the result select.
package alu_slice_pkg;

    // Result source selected by op_code[1:0]
    typedef enum logic [1:0] {
        SRC_AND  = 2'b00,
        SRC_OR   = 2'b01,
        SRC_SUM  = 2'b10,
        SRC_LESS = 2'b11
    } result_src_e;

    localparam int SEL_LINES = 4;

    // Full operation codes
    localparam logic [2:0] OPC_AND = 3'b000;
    localparam logic [2:0] OPC_OR  = 3'b001;
    localparam logic [2:0] OPC_ADD = 3'b010;
    localparam logic [2:0] OPC_SUB = 3'b110;
    localparam logic [2:0] OPC_SLT = 3'b111;

endpackage

// File: rtl/alu_ctrl_driver.sv
// Module: alu_ctrl_driver
// Turns the 3-bit operation code into the shared control lines that run to
// every slice: one B-invert line and one-hot result-select lines.
// Assumes: purely combinational; the one-hot lines are bit-indexed by
// result_src_e.
module alu_ctrl_driver
    import alu_slice_pkg::*;
(
    input  logic [2:0]           op_code,
    output logic                 inv_b,
    output logic [SEL_LINES-1:0] sel_oh
);

    result_src_e src;

    // Split the code into invert and source fields
    always_comb begin
        inv_b = op_code[2];
        src   = result_src_e'(op_code[1:0]);
    end

    // One select line per result source
    for (genvar k = 0; k < SEL_LINES; k++) begin : g_sel
        assign sel_oh[k] = (src == result_src_e'(k));
    end

endmodule

// File: rtl/alu_full_adder.sv
// Module: alu_full_adder
// One-bit full adder used inside each ALU slice.
// Assumes: purely combinational.
module alu_full_adder (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);

    logic prop;

    // Sum and carry from propagate/generate terms
    always_comb begin
        prop = x ^ y;
        s    = prop ^ ci;
        co   = (x & y) | (prop & ci);
    end

endmodule

// File: rtl/alu_bit_slice.sv
// Module: alu_bit_slice
// One bit of the ALU: conditional B inversion, AND, OR, full adder and a
// one-hot result selector. The adder sum bit is also brought out as set_bit.
// Assumes: sel_oh is one-hot and indexed by result_src_e.
module alu_bit_slice
    import alu_slice_pkg::*;
(
    input  logic                 a_bit,
    input  logic                 b_bit,
    input  logic                 carry_in,
    input  logic                 less_in,
    input  logic                 inv_b,
    input  logic [SEL_LINES-1:0] sel_oh,
    output logic                 res_bit,
    output logic                 carry_out,
    output logic                 set_bit
);

    logic b_eff;
    logic and_v;
    logic or_v;
    logic sum_v;
    logic [SEL_LINES-1:0] cand;

    // Second operand after optional inversion
    always_comb b_eff = b_bit ^ inv_b;

    // Logic-unit outputs
    always_comb begin
        and_v = a_bit & b_eff;
        or_v  = a_bit | b_eff;
    end

    alu_full_adder u_fa (
        .x  (a_bit),
        .y  (b_eff),
        .ci (carry_in),
        .s  (sum_v),
        .co (carry_out)
    );

    // Gate each candidate with its select line, then merge
    always_comb begin
        cand[SRC_AND]  = and_v   & sel_oh[SRC_AND];
        cand[SRC_OR]   = or_v    & sel_oh[SRC_OR];
        cand[SRC_SUM]  = sum_v   & sel_oh[SRC_SUM];
        cand[SRC_LESS] = less_in & sel_oh[SRC_LESS];
        res_bit        = |cand;
        set_bit        = sum_v;
    end

endmodule

// File: rtl/ripple_slt_alu.sv
// Module: ripple_slt_alu
// WIDTH-bit ALU made of identical slices with a ripple carry chain. The
// carry into slice 0 is the B-invert line. The top slice's sum bit feeds the
// less input of slice 0; every other less input is tied low.
// Assumes: purely combinational; signed compare uses only the sign of the
// wrapped difference (no overflow correction).
module ripple_slt_alu
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_code,
    output logic [WIDTH-1:0] alu_out,
    output logic             carry_top
);

    localparam int MSB = WIDTH - 1;

    logic                 inv_b;
    logic [SEL_LINES-1:0] sel_oh;
    logic [WIDTH:0]       chain;
    logic [WIDTH-1:0]     set_vec;
    logic [WIDTH-1:0]     less_vec;

    alu_ctrl_driver u_ctrl (
        .op_code (op_code),
        .inv_b   (inv_b),
        .sel_oh  (sel_oh)
    );

    // Carry seed and top carry out
    assign chain[0]  = inv_b;
    assign carry_top = chain[WIDTH];

    // Less routing: top sum bit to slice 0, others low
    always_comb begin
        less_vec    = '0;
        less_vec[0] = set_vec[MSB];
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice u_slice (
            .a_bit     (opnd_a[i]),
            .b_bit     (opnd_b[i]),
            .carry_in  (chain[i]),
            .less_in   (less_vec[i]),
            .inv_b     (inv_b),
            .sel_oh    (sel_oh),
            .res_bit   (alu_out[i]),
            .carry_out (chain[i+1]),
            .set_bit   (set_vec[i])
        );
    end

    // Port-level checks of the main operations
    always_comb begin
        if (op_code == OPC_ADD) begin
            assert_add_sum_R2: assert ({carry_top, alu_out} ==
                ({1'b0, opnd_a} + {1'b0, opnd_b}))
                else $error("R2 add mismatch");
        end
        if (op_code == OPC_SUB) begin
            assert_sub_diff_R3: assert (alu_out == WIDTH'(opnd_a - opnd_b))
                else $error("R3 sub mismatch");
            assert_sub_carry_R7: assert (carry_top == (opnd_a >= opnd_b))
                else $error("R7 sub carry mismatch");
        end
        if (op_code == OPC_AND) begin
            assert_and_R4: assert (alu_out == (opnd_a & opnd_b))
                else $error("R4 and mismatch");
        end
        if (op_code == OPC_OR) begin
            assert_or_R5: assert (alu_out == (opnd_a | opnd_b))
                else $error("R5 or mismatch");
        end
        if (op_code[1:0] == SRC_LESS) begin
            assert_less_upper_zero_R6: assert (alu_out[MSB:1] == '0)
                else $error("R6 upper bits not zero");
        end
    end

endmodule

// File: tb/test_ripple_slt_alu.sv
`timescale 1ns/1ps
module test_ripple_slt_alu;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [2:0]   code = 3'b000;
    logic [W-1:0] y_out;
    logic         c_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    ripple_slt_alu #(.WIDTH(W)) i_ripple_slt_alu (
        .opnd_a    (a_in),
        .opnd_b    (b_in),
        .op_code   (code),
        .alu_out   (y_out),
        .carry_top (c_out)
    );

    always #4 clk = ~clk;

    // Drive on negedge, sample 1 ns later
    task automatic apply(input logic [2:0] c, input logic [W-1:0] a,
                         input logic [W-1:0] b);
        @(negedge clk);
        code = c; a_in = a; b_in = b;
        #1;
    endtask

    task automatic cmp_res(input string tag, input logic [W-1:0] exp);
        n_checks++;
        if (y_out !== exp) begin
            n_fail++;
            $display("FAIL %s code=%b a=%h b=%h actual=%h expected=%h",
                     tag, code, a_in, b_in, y_out, exp);
        end
    endtask

    task automatic cmp_carry(input string tag, input logic exp);
        n_checks++;
        if (c_out !== exp) begin
            n_fail++;
            $display("FAIL %s carry code=%b a=%h b=%h actual=%b expected=%b",
                     tag, code, a_in, b_in, c_out, exp);
        end
    endtask

    // Initial all-zero inputs give zero result, zero carry
    task automatic t_idle;
        apply(3'b000, '0, '0);
        cmp_res("R4", '0);
        cmp_carry("R7", 1'b0);
    endtask

    // R2 and R7: addition and its carry
    task automatic t_add;
        logic [W:0] full;
        for (int a = 0; a < 256; a += 17)
            for (int b = 0; b < 256; b += 13) begin
                apply(3'b010, W'(a), W'(b));
                full = (W+1)'(a + b);
                cmp_res("R2", full[W-1:0]);
                cmp_carry("R7", full[W]);
            end
        apply(3'b010, 8'hFF, 8'h01);
        cmp_res("R2", 8'h00);
        cmp_carry("R7", 1'b1);
    endtask

    // R3 and R7: subtraction, carry = no borrow
    task automatic t_sub;
        for (int a = 0; a < 256; a += 19)
            for (int b = 0; b < 256; b += 11) begin
                apply(3'b110, W'(a), W'(b));
                cmp_res("R3", W'(a - b));
                cmp_carry("R7", a >= b);
            end
        apply(3'b110, 8'h5A, 8'h5A);
        cmp_res("R3", 8'h00);
        cmp_carry("R7", 1'b1);
    endtask

    // R4, R5, R8: logic ops with and without inversion
    task automatic t_logic;
        for (int a = 0; a < 256; a += 23)
            for (int b = 0; b < 256; b += 29) begin
                apply(3'b000, W'(a), W'(b));
                cmp_res("R4", W'(a) & W'(b));
                apply(3'b001, W'(a), W'(b));
                cmp_res("R5", W'(a) | W'(b));
                apply(3'b100, W'(a), W'(b));
                cmp_res("R8", W'(a) & ~W'(b));
                cmp_carry("R7", a >= b);
                apply(3'b101, W'(a), W'(b));
                cmp_res("R8", W'(a) | ~W'(b));
            end
        apply(3'b001, 8'hF0, 8'h0F);
        cmp_res("R5", 8'hFF);
        cmp_carry("R7", 1'b0);
        apply(3'b000, 8'hF0, 8'h0F);
        cmp_res("R4", 8'h00);
    endtask

    // R6: sign of wrapped difference, including overflow cases
    task automatic t_slt;
        logic [W-1:0] d;
        for (int a = 0; a < 256; a += 17)
            for (int b = 0; b < 256; b += 15) begin
                apply(3'b111, W'(a), W'(b));
                d = W'(a - b);
                cmp_res("R6", {{(W-1){1'b0}}, d[W-1]});
            end
        apply(3'b111, 8'hFF, 8'h01);   // -1 < 1
        cmp_res("R6", 8'h01);
        apply(3'b111, 8'h01, 8'hFF);   // 1 > -1
        cmp_res("R6", 8'h00);
        apply(3'b111, 8'h80, 8'h01);   // overflow: wrong answer 0
        cmp_res("R6", 8'h00);
        apply(3'b111, 8'h7F, 8'h80);   // overflow: wrong answer 1
        cmp_res("R6", 8'h01);
        apply(3'b111, 8'h33, 8'h33);
        cmp_res("R6", 8'h00);
        cmp_carry("R7", 1'b1);
    endtask

    // R9 and R1: less path without inversion reports sign of sum
    task automatic t_less_add;
        logic [W-1:0] s;
        for (int a = 0; a < 256; a += 31)
            for (int b = 0; b < 256; b += 37) begin
                apply(3'b011, W'(a), W'(b));
                s = W'(a + b);
                cmp_res("R9", {{(W-1){1'b0}}, s[W-1]});
            end
        apply(3'b011, 8'h40, 8'h40);
        cmp_res("R1", 8'h01);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_add();
        t_sub();
        t_logic();
        t_slt();
        t_less_add();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                     n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                     n_checks, n_fail);
            $finish;
        end
    end

endmodule